// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter Slice

This block is a presettable reversible counter for a single-clock synchronous design. Rather than one clock plus a direction bit, it takes two separate count strobes, one to count up and one to count down. Both strobes idle high. Each strobe passes through a synchronizer and an edge detector running on the system clock, so the strobes may come from unrelated logic. A step in one direction is accepted only while the other strobe is high.

A synchronous active-low load copies a preset word into the counter. A synchronous active-high clear forces the counter to zero. The counter either wraps across the full binary range or wraps at nine, as chosen by a parameter.

Two active-low outputs, carry and borrow, let slices be chained with no glue logic. Carry is low while the synchronized up strobe is low and the counter sits at its maximum. Borrow is low while the synchronized down strobe is low and the counter sits at zero. Each pulse is therefore as wide as the low phase of the strobe that caused it. Its rising edge coincides with the step that wraps the counter, so it acts as the next slice's count strobe.

Top module: `updown_slice`

## Requirements
- R1: While `clear` is high, the count becomes 0 at the next clock edge, regardless of `load_n`, `preset` and the strobes.
- R2: While `clear` is low and `load_n` is low, the count takes the value of `preset` at the next clock edge, and no strobe edge changes it.
- R3: A low-to-high change on `up_req` while `dn_req` is high adds one to the count. The new count appears after the third rising clock edge that follows the input change (two synchronizer stages plus the count register).
- R4: A low-to-high change on `dn_req` while `up_req` is high subtracts one, with the same latency as R3.
- R5: A rising edge on one strobe while the other strobe is low is ignored, and the count holds.
- R6: If qualified rising edges of both strobes reach the counter in the same cycle, the count holds.
- R7: In binary mode (`DECIMAL`=0, 4 bits), an up step from 15 gives 0 and a down step from 0 gives 15.
- R8: In decimal mode (`DECIMAL`=1), an up step from 9 gives 0 and a down step from 0 gives 9. An up step from a preset value above 9 gives 0.
- R9: `carry_n` is 1 at idle. It is 0 exactly while the synchronized up strobe is low and the count equals the maximum (15 binary, 9 decimal). A low phase of N cycles on `up_req` at the maximum therefore gives exactly N low cycles on `carry_n`.
- R10: `borrow_n` is 1 at idle. It is 0 exactly while the synchronized down strobe is low and the count is 0. A low phase of N cycles on `dn_req` at zero gives exactly N low cycles on `borrow_n`.
- R11: When one slice's `carry_n` drives the next slice's `up_req` and its `borrow_n` drives the next slice's `dn_req`, an up wrap of the first slice adds one to the second slice and a down wrap subtracts one.
- R12: After reset, the count is 0 and `carry_n` and `borrow_n` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear to zero, highest priority |
| load_n | input | 1 | Active-low synchronous preset enable |
| preset | input | WIDTH | Value loaded while `load_n` is low |
| up_req | input | 1 | Up-count strobe, idle high, counts on its rising edge |
| dn_req | input | 1 | Down-count strobe, idle high, counts on its rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low overflow pulse for cascading |
| borrow_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
Clear and load can fall in the same cycle as a strobe step, and so can the up and down steps. The bench provokes these overlaps by holding `clear` high with `load_n` low and a preset applied, and by holding `load_n` low across a full up strobe. It also raises both strobes on the same clock so that both qualified edges leave the synchronizers together. In each case the outcome is judged only at the `count` port: zero for clear, the preset value for load, and the unchanged count when the two step directions collide.

// File: rtl/updown_pkg.sv
package updown_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_t;

   // Top value of the counting range for a given width and wrap mode.
   function automatic int unsigned top_value(input int unsigned width, input bit decimal);
      if (decimal) return 9;
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/updown_edge.sv
module updown_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic level,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("updown_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   // Synchronizer chain, idle level is high so reset loads ones.
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= 1'b1;
            else        stage_q[g] <= req;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= 1'b1;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign level = stage_q[STAGES-1];
   assign rise  = level & ~prev_q;

   // R3
   rise_single_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/updown_core.sv
module updown_core
   import updown_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load_n,
   input  logic [WIDTH-1:0] preset,
   input  logic             up_step,
   input  logic             dn_step,
   output logic [WIDTH-1:0] count
);

   localparam int unsigned TOPV = top_value(WIDTH, DECIMAL);
   localparam logic [WIDTH-1:0] MAXV = WIDTH'(TOPV);

   step_t            step;
   logic [WIDTH-1:0] inc_val;
   logic [WIDTH-1:0] dec_val;
   logic [WIDTH-1:0] next_val;

   always_comb begin
      unique case ({up_step, dn_step})
         2'b10:   step = STEP_INC;
         2'b01:   step = STEP_DEC;
         default: step = STEP_HOLD;
      endcase
   end

   if (DECIMAL) begin : g_dec
      assign inc_val = (count >= MAXV) ? '0 : count + 1'b1;
      assign dec_val = (count == '0) ? MAXV : count - 1'b1;
   end else begin : g_bin
      assign inc_val = count + 1'b1;
      assign dec_val = count - 1'b1;
   end

   always_comb begin
      next_val = count;
      if (clear)             next_val = '0;
      else if (!load_n)      next_val = preset;
      else if (step == STEP_INC) next_val = inc_val;
      else if (step == STEP_DEC) next_val = dec_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= next_val;
   end

   // R1
   clear_wins_chk : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);

   // R2
   load_takes_preset_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load_n) |=> count == $past(preset));

   // R6
   both_steps_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_step && dn_step) |=> $stable(count));

   // R7
   wrap_up_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_step && !dn_step && count == MAXV) |=> count == '0);

   // R7
   wrap_down_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && dn_step && !up_step && count == '0) |=> count == MAXV);

endmodule

// File: rtl/updown_cascade.sv
module updown_cascade #(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] MAXV = '1
) (
   input  logic             up_level,
   input  logic             dn_level,
   input  logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);

   logic at_top;
   logic at_zero;

   assign at_top   = (count == MAXV);
   assign at_zero  = (count == '0);
   assign carry_n  = ~(~up_level & at_top);
   assign borrow_n = ~(~dn_level & at_zero);

endmodule

// File: rtl/updown_slice.sv
module updown_slice
   import updown_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter bit          DECIMAL     = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load_n,
   input  logic [WIDTH-1:0] preset,
   input  logic             up_req,
   input  logic             dn_req,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);

   localparam int unsigned TOPV = top_value(WIDTH, DECIMAL);
   localparam logic [WIDTH-1:0] MAXV = WIDTH'(TOPV);

   if (WIDTH < 1) begin : g_bad_width
      $error("updown_slice: WIDTH must be at least 1");
   end
   if (DECIMAL && WIDTH < 4) begin : g_bad_dec
      $error("updown_slice: decimal wrap needs WIDTH of at least 4");
   end

   logic up_level, up_rise;
   logic dn_level, dn_rise;
   logic up_step, dn_step;

   updown_edge #(.STAGES(SYNC_STAGES)) u_up_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (up_req),
      .level (up_level),
      .rise  (up_rise)
   );

   updown_edge #(.STAGES(SYNC_STAGES)) u_dn_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (dn_req),
      .level (dn_level),
      .rise  (dn_rise)
   );

   // A step counts only while the opposite strobe rests high.
   assign up_step = up_rise & dn_level;
   assign dn_step = dn_rise & up_level;

   updown_core #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .load_n  (load_n),
      .preset  (preset),
      .up_step (up_step),
      .dn_step (dn_step),
      .count   (count)
   );

   updown_cascade #(.WIDTH(WIDTH), .MAXV(MAXV)) u_cascade (
      .up_level (up_level),
      .dn_level (dn_level),
      .count    (count),
      .carry_n  (carry_n),
      .borrow_n (borrow_n)
   );

   // R9
   carry_at_top_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (count == MAXV && !up_level));

   // R10
   borrow_at_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (count == '0 && !dn_level));

   // R5
   gated_rise_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_rise && !dn_level && !dn_rise) |=> $stable(count));

endmodule

// File: tb/sim_updown_slice.sv
module sim_updown_slice;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear = 1'b0;
   logic       load_n = 1'b1;
   logic [3:0] preset = '0;
   logic       up_req = 1'b1;
   logic       dn_req = 1'b1;
   logic [3:0] count, count_dec, count_hi;
   logic       carry_n, borrow_n, carry_dec, borrow_dec, carry_hi, borrow_hi;
   logic       load_hi_n = 1'b1;
   logic [3:0] preset_hi = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   updown_slice #(.WIDTH(4), .DECIMAL(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset),
      .up_req(up_req), .dn_req(dn_req), .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

   // Next slice in a chain, fed only by u0's cascade outputs.
   updown_slice #(.WIDTH(4), .DECIMAL(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .clear(1'b0), .load_n(load_hi_n), .preset(preset_hi),
      .up_req(carry_n), .dn_req(borrow_n), .count(count_hi), .carry_n(carry_hi), .borrow_n(borrow_hi));

   // Decimal-wrap slice sharing u0's stimulus.
   updown_slice #(.WIDTH(4), .DECIMAL(1'b1)) u2 (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset),
      .up_req(up_req), .dn_req(dn_req), .count(count_dec), .carry_n(carry_dec), .borrow_n(borrow_dec));

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [3:0] v);
      preset = v; load_n = 1'b0;
      ticks(1);
      load_n = 1'b1;
      ticks(1);
   endtask

   task automatic pulse_up(input int low);
      up_req = 1'b0; ticks(low);
      up_req = 1'b1; ticks(4);
   endtask

   task automatic pulse_dn(input int low);
      dn_req = 1'b0; ticks(low);
      dn_req = 1'b1; ticks(4);
   endtask

   task automatic t_reset();
      chk("R12 count after reset", count, 0);
      chk("R12 carry_n after reset", carry_n, 1);
      chk("R12 borrow_n after reset", borrow_n, 1);
   endtask

   task automatic t_load();
      do_load(4'd5);
      chk("R2 load value", count, 5);
      preset = 4'd7; load_n = 1'b0;
      pulse_up(3);
      pulse_dn(3);
      chk("R2 load holds over strobes", count, 7);
      load_n = 1'b1;
      ticks(1);
   endtask

   task automatic t_up_timing();
      do_load(4'd5);
      up_req = 1'b0; ticks(4);
      up_req = 1'b1; ticks(2);
      chk("R3 no change before third edge", count, 5);
      ticks(1);
      chk("R3 increment on third edge", count, 6);
      ticks(2);
   endtask

   task automatic t_down();
      do_load(4'd6);
      dn_req = 1'b0; ticks(4);
      dn_req = 1'b1; ticks(2);
      chk("R4 no change before third edge", count, 6);
      ticks(1);
      chk("R4 decrement", count, 5);
      ticks(2);
   endtask

   task automatic t_ignore();
      do_load(4'd5);
      dn_req = 1'b0; ticks(3);
      pulse_up(3);
      chk("R5 up edge ignored while down low", count, 5);
      dn_req = 1'b1; ticks(4);
      chk("R4 release of down strobe counts down", count, 4);
   endtask

   task automatic t_both();
      do_load(4'd8);
      up_req = 1'b0; dn_req = 1'b0; ticks(4);
      up_req = 1'b1; dn_req = 1'b1; ticks(5);
      chk("R6 simultaneous edges hold", count, 8);
   endtask

   task automatic t_clear();
      do_load(4'd9);
      clear = 1'b1; load_n = 1'b0; preset = 4'd12;
      ticks(1);
      chk("R1 clear beats load", count, 0);
      load_n = 1'b1;
      pulse_up(3);
      chk("R1 clear beats up step", count, 0);
      clear = 1'b0;
      ticks(1);
   endtask

   task automatic t_wrap();
      do_load(4'd15);
      pulse_up(3);
      chk("R7 up wrap 15 to 0", count, 0);
      pulse_dn(3);
      chk("R7 down wrap 0 to 15", count, 15);
   endtask

   task automatic t_carry();
      int lows = 0;
      do_load(4'd15);
      up_req = 1'b0;
      for (int i = 0; i < 6; i++) begin ticks(1); if (!carry_n) lows++; end
      up_req = 1'b1;
      for (int i = 0; i < 6; i++) begin ticks(1); if (!carry_n) lows++; end
      chk("R9 carry_n low width equals strobe low width", lows, 6);
      chk("R9 carry_n idle after wrap", carry_n, 1);
      chk("R7 count after carry wrap", count, 0);
   endtask

   task automatic t_borrow();
      int lows = 0;
      do_load(4'd0);
      dn_req = 1'b0;
      for (int i = 0; i < 4; i++) begin ticks(1); if (!borrow_n) lows++; end
      dn_req = 1'b1;
      for (int i = 0; i < 6; i++) begin ticks(1); if (!borrow_n) lows++; end
      chk("R10 borrow_n low width equals strobe low width", lows, 4);
      chk("R10 borrow_n idle after wrap", borrow_n, 1);
      do_load(4'd3);
      dn_req = 1'b0; ticks(4);
      chk("R10 borrow_n high away from zero", borrow_n, 1);
      dn_req = 1'b1; ticks(4);
   endtask

   task automatic t_decimal();
      do_load(4'd9);
      up_req = 1'b0; ticks(3);
      chk("R9 decimal carry_n low at 9", carry_dec, 0);
      chk("R9 binary carry_n high at 9", carry_n, 1);
      up_req = 1'b1; ticks(4);
      chk("R8 decimal 9 up to 0", count_dec, 0);
      do_load(4'd0);
      pulse_dn(3);
      chk("R8 decimal 0 down to 9", count_dec, 9);
      do_load(4'd12);
      pulse_up(3);
      chk("R8 decimal preset 12 up to 0", count_dec, 0);
      chk("R7 binary preset 12 up to 13", count, 13);
   endtask

   task automatic t_chain();
      preset_hi = 4'd3; load_hi_n = 1'b0;
      do_load(4'd15);
      load_hi_n = 1'b1;
      ticks(2);
      pulse_up(3);
      ticks(6);
      chk("R11 low slice wrapped up", count, 0);
      chk("R11 carry advances next slice", count_hi, 4);
      pulse_dn(3);
      ticks(6);
      chk("R11 low slice wrapped down", count, 15);
      chk("R11 borrow retreats next slice", count_hi, 3);
   endtask

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(2);
      t_reset();
      t_load();
      t_up_timing();
      t_down();
      t_ignore();
      t_both();
      t_clear();
      t_wrap();
      t_carry();
      t_borrow();
      t_decimal();
      t_chain();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule